// File: doc/BRIEF.md
# Board System Control Register Block

This block is the software-visible register file of a development board's system controller. It sits on a simple 32-bit read/write bus with byte offsets and word-aligned accesses. Through it software reads the board identity numbers, the configuration switches, the card-slot status and which daughterboard site is the master. It also drives eight user LEDs and the active-low flash write-protect control.

Two flag words give firmware a way to pass state across resets. Each is read at one offset, but written only through a set alias and a clear alias. In both aliases a 1 in the write data acts on that bit and a 0 leaves it alone, so independent agents can update single bits without a read-modify-write. The volatile flag word is cleared by every reset, and hardware can also clear its bits. The non-volatile flag word survives the ordinary reset and is cleared only by power-on reset.

Reads are combinational: the data for the addressed register is presented in the same cycle that the read is selected. Writes take effect on the next rising clock edge.

Top module: `sysreg_top`

## Requirements
- R1: After reset the volatile flags, the non-volatile flags and the LED register read 0, `led_out` is 0, and the flash control bit is 0, so `flash_wp_n` is 0 (protected).
- R2: Offset 0x000 reads the motherboard number in bits 27:16, with all other bits 0. Offset 0x084 reads the site-1 number in bits 11:0 and offset 0x088 reads the site-2 number in bits 11:0, with the upper bits 0.
- R3: Offset 0x004 reads `sw_in` unchanged.
- R4: Offset 0x008 holds an 8-bit LED value in bits 7:0. It can be read and written, it drives `led_out`, and its bits 31:8 read 0.
- R5: Offset 0x048 reads `card_present` in bit 0 and `card_wprot` in bit 1. Offset 0x04C holds a writable bit 0 that drives `flash_wp_n`.
- R6: Offset 0x060 reads `master_site2` in bit 14 (1 means site 2 is the master, 0 means site 1), with all other bits 0.
- R7: A read of 0x030 returns the volatile flags. A write to 0x030 sets each flag bit where the data has a 1. A write to 0x034 clears each flag bit where the data has a 1. A read of 0x034 returns 0.
- R8: Writing all ones to 0x034 and then a value V to 0x030 leaves the volatile flags equal to V.
- R9: The non-volatile flags follow the same scheme: read and set at 0x038, clear at 0x03C. A read of 0x03C returns 0.
- R10: `rst_n` low clears the volatile flags, the LED register and the flash bit, but leaves the non-volatile flags unchanged. `por_n` low clears everything, including the non-volatile flags. Bus writes are ignored while either reset is low.
- R11: Reads of unmapped offsets return 0 and writes to them change nothing. Writes to the read-only registers (0x000, 0x004, 0x048, 0x060, 0x084, 0x088) have no effect.
- R12: Each bit of `flag_hw_clr` clears that volatile flag bit on the next edge. When a write to 0x030 sets the same bit in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; non-volatile flags keep their value |
| por_n | input | 1 | Synchronous power-on reset, active low; clears all state |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a selected read, 0 otherwise |
| sw_in | input | 32 | Configuration switch levels |
| card_present | input | 1 | Card inserted in the slot |
| card_wprot | input | 1 | Card write-protect tab |
| master_site2 | input | 1 | 1 when daughterboard site 2 is the master |
| board_id_mb | input | 12 | Motherboard number |
| board_id_db1 | input | 12 | Site-1 daughterboard number |
| board_id_db2 | input | 12 | Site-2 daughterboard number |
| flag_hw_clr | input | 32 | Per-bit hardware clear request for the volatile flags |
| led_out | output | 8 | User LED drive |
| flash_wp_n | output | 1 | Flash write protect, active low |

## Verification
On every cycle the assertions check the flag-word rules: after a set-alias write the written bits are 1, after a clear-alias write they are 0, and a hardware clear is honoured except where a same-cycle set overrides it. They also check that the non-volatile word holds its value through an ordinary reset, and that unmapped offsets and the MISC word read back correctly. Only the bench's scenarios can show the whole identity and status decoding, the clear-all then set sequence, the read-only registers ignoring writes, the LED and flash pins following their registers, and the split between the two resets across a full sequence.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
    localparam logic [11:0] OFF_ID      = 12'h000;
    localparam logic [11:0] OFF_SW      = 12'h004;
    localparam logic [11:0] OFF_LED     = 12'h008;
    localparam logic [11:0] OFF_FLG_SET = 12'h030;
    localparam logic [11:0] OFF_FLG_CLR = 12'h034;
    localparam logic [11:0] OFF_NV_SET  = 12'h038;
    localparam logic [11:0] OFF_NV_CLR  = 12'h03C;
    localparam logic [11:0] OFF_CARD    = 12'h048;
    localparam logic [11:0] OFF_FLASH   = 12'h04C;
    localparam logic [11:0] OFF_MISC    = 12'h060;
    localparam logic [11:0] OFF_PID0    = 12'h084;
    localparam logic [11:0] OFF_PID1    = 12'h088;

    localparam int ID_SHIFT      = 16;
    localparam int MISC_SITE_BIT = 14;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ID,
        SEL_SW,
        SEL_LED,
        SEL_FLG_SET,
        SEL_FLG_CLR,
        SEL_NV_SET,
        SEL_NV_CLR,
        SEL_CARD,
        SEL_FLASH,
        SEL_MISC,
        SEL_PID0,
        SEL_PID1
    } reg_sel_e;
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    always_comb begin
        unique case (addr)
            AW'(OFF_ID):      sel = SEL_ID;
            AW'(OFF_SW):      sel = SEL_SW;
            AW'(OFF_LED):     sel = SEL_LED;
            AW'(OFF_FLG_SET): sel = SEL_FLG_SET;
            AW'(OFF_FLG_CLR): sel = SEL_FLG_CLR;
            AW'(OFF_NV_SET):  sel = SEL_NV_SET;
            AW'(OFF_NV_CLR):  sel = SEL_NV_CLR;
            AW'(OFF_CARD):    sel = SEL_CARD;
            AW'(OFF_FLASH):   sel = SEL_FLASH;
            AW'(OFF_MISC):    sel = SEL_MISC;
            AW'(OFF_PID0):    sel = SEL_PID0;
            AW'(OFF_PID1):    sel = SEL_PID1;
            default:          sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/sysreg_flagword.sv
module sysreg_flagword #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         wipe,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] q
);
    logic [W-1:0] set_mask;
    logic [W-1:0] clr_mask;

    always_comb begin
        set_mask = set_en ? wdata : '0;
        clr_mask = (clr_en ? wdata : '0) | hw_clr;
    end

    // set applied last: a bus set beats a same-cycle clear request
    always_ff @(posedge clk) begin
        if (wipe) q <= '0;
        else      q <= (q & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/sysreg_top.sv
module sysreg_top
    import sysreg_pkg::*;
#(
    parameter int   DW        = 32,
    parameter int   AW        = 12,
    parameter int   LED_W     = 8,
    parameter int   BID_W     = 12,
    parameter logic FLASH_RST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [DW-1:0]    sw_in,
    input  logic             card_present,
    input  logic             card_wprot,
    input  logic             master_site2,
    input  logic [BID_W-1:0] board_id_mb,
    input  logic [BID_W-1:0] board_id_db1,
    input  logic [BID_W-1:0] board_id_db2,
    input  logic [DW-1:0]    flag_hw_clr,
    output logic [LED_W-1:0] led_out,
    output logic             flash_wp_n
);
    reg_sel_e         sel;
    logic             wr;
    logic             wipe_warm;
    logic             wipe_cold;
    logic [DW-1:0]    vol_q;
    logic [DW-1:0]    nv_q;
    logic [LED_W-1:0] led_q;
    logic             flash_q;
    logic [DW-1:0]    rd_mux;

    assign wipe_warm = !rst_n || !por_n;
    assign wipe_cold = !por_n;
    assign wr        = bus_sel && bus_we && !wipe_warm;

    sysreg_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    sysreg_flagword #(.W(DW)) u_vol (
        .clk    (clk),
        .wipe   (wipe_warm),
        .set_en (wr && sel == SEL_FLG_SET),
        .clr_en (wr && sel == SEL_FLG_CLR),
        .wdata  (bus_wdata),
        .hw_clr (flag_hw_clr),
        .q      (vol_q)
    );

    sysreg_flagword #(.W(DW)) u_nv (
        .clk    (clk),
        .wipe   (wipe_cold),
        .set_en (wr && sel == SEL_NV_SET),
        .clr_en (wr && sel == SEL_NV_CLR),
        .wdata  (bus_wdata),
        .hw_clr ('0),
        .q      (nv_q)
    );

    always_ff @(posedge clk) begin
        if (wipe_warm) begin
            led_q   <= '0;
            flash_q <= FLASH_RST;
        end else if (wr) begin
            if (sel == SEL_LED)   led_q   <= bus_wdata[LED_W-1:0];
            if (sel == SEL_FLASH) flash_q <= bus_wdata[0];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_ID:      rd_mux = DW'(board_id_mb) << ID_SHIFT;
            SEL_SW:      rd_mux = sw_in;
            SEL_LED:     rd_mux = DW'(led_q);
            SEL_FLG_SET: rd_mux = vol_q;
            SEL_NV_SET:  rd_mux = nv_q;
            SEL_CARD:    rd_mux = DW'({card_wprot, card_present});
            SEL_FLASH:   rd_mux = DW'(flash_q);
            SEL_MISC:    rd_mux = DW'(master_site2) << MISC_SITE_BIT;
            SEL_PID0:    rd_mux = DW'(board_id_db1);
            SEL_PID1:    rd_mux = DW'(board_id_db2);
            default:     rd_mux = '0;
        endcase
    end

    assign bus_rdata  = (bus_sel && !bus_we) ? rd_mux : '0;
    assign led_out    = led_q;
    assign flash_wp_n = flash_q;
endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        por_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        master_site2,
    input logic [31:0] flag_hw_clr,
    input logic [31:0] vol_q,
    input logic [31:0] nv_q
);
    logic        live;
    logic        wr;
    logic        rd;
    logic        mapped;
    logic [31:0] set_data;

    assign live = rst_n && por_n;
    assign wr   = bus_sel && bus_we && live;
    assign rd   = bus_sel && !bus_we;
    assign mapped = bus_addr inside {12'h000, 12'h004, 12'h008, 12'h030, 12'h038,
                                     12'h048, 12'h04C, 12'h060, 12'h084, 12'h088};
    assign set_data = (wr && bus_addr == 12'h030) ? bus_wdata : 32'h0;

    a_r7_set_sticks: assert property (@(posedge clk) disable iff (!live)
        $past(wr && bus_addr == 12'h030 && live) |-> ((vol_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r7_clr_sticks: assert property (@(posedge clk) disable iff (!live)
        $past(wr && bus_addr == 12'h034 && live) |-> ((vol_q & $past(bus_wdata)) == 32'h0));

    a_r9_nv_set: assert property (@(posedge clk) disable iff (!live)
        $past(wr && bus_addr == 12'h038 && live) |-> ((nv_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r9_nv_clr: assert property (@(posedge clk) disable iff (!live)
        $past(wr && bus_addr == 12'h03C && live) |-> ((nv_q & $past(bus_wdata)) == 32'h0));

    a_r10_nv_hold: assert property (@(posedge clk) disable iff (!por_n)
        $past(!rst_n && por_n) |-> (nv_q == $past(nv_q)));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!live)
        (rd && !mapped) |-> (bus_rdata == 32'h0));

    a_r6_misc_read: assert property (@(posedge clk) disable iff (!live)
        (rd && bus_addr == 12'h060) |-> (bus_rdata == {17'h0, master_site2, 14'h0}));

    a_r12_hw_clear: assert property (@(posedge clk) disable iff (!live)
        $past(live) |-> ((vol_q & $past(flag_hw_clr) & ~$past(set_data)) == 32'h0));
endmodule

bind sysreg_top sysreg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_n        (por_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .master_site2 (master_site2),
    .flag_hw_clr  (flag_hw_clr),
    .vol_q        (vol_q),
    .nv_q         (nv_q)
);

// File: tb/sim_sysreg_top.sv
module sim_sysreg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] sw_in = 32'hA5A5_0F0F;
    logic        card_present = 1'b1;
    logic        card_wprot = 1'b0;
    logic        master_site2 = 1'b1;
    logic [11:0] board_id_mb = 12'h1A2;
    logic [11:0] board_id_db1 = 12'h0B3;
    logic [11:0] board_id_db2 = 12'h7C4;
    logic [31:0] flag_hw_clr = '0;
    logic [7:0]  led_out;
    logic        flash_wp_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sysreg_top u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sw_in(sw_in), .card_present(card_present), .card_wprot(card_wprot),
        .master_site2(master_site2), .board_id_mb(board_id_mb),
        .board_id_db1(board_id_db1), .board_id_db2(board_id_db2),
        .flag_hw_clr(flag_hw_clr), .led_out(led_out), .flash_wp_n(flash_wp_n)
    );

    // {req, is_write, addr, data}; for reads data is the expected value
    typedef logic [48:0] vec_t;
    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        {4'd2,  1'b0, 12'h000, 32'h01A2_0000},  // R2
        {4'd2,  1'b0, 12'h084, 32'h0000_00B3},  // R2
        {4'd2,  1'b0, 12'h088, 32'h0000_07C4},  // R2
        {4'd3,  1'b0, 12'h004, 32'hA5A5_0F0F},  // R3
        {4'd5,  1'b0, 12'h048, 32'h0000_0001},  // R5
        {4'd6,  1'b0, 12'h060, 32'h0000_4000},  // R6
        {4'd4,  1'b1, 12'h008, 32'hFFFF_FF5A},  // R4
        {4'd4,  1'b0, 12'h008, 32'h0000_005A},  // R4
        {4'd7,  1'b1, 12'h030, 32'h0000_00F0},  // R7
        {4'd7,  1'b1, 12'h030, 32'h0000_0003},  // R7
        {4'd7,  1'b0, 12'h030, 32'h0000_00F3},  // R7
        {4'd7,  1'b1, 12'h034, 32'h0000_0011},  // R7
        {4'd7,  1'b0, 12'h030, 32'h0000_00E2},  // R7
        {4'd8,  1'b1, 12'h034, 32'hFFFF_FFFF},  // R8
        {4'd8,  1'b1, 12'h030, 32'h1234_5678},  // R8
        {4'd8,  1'b0, 12'h030, 32'h1234_5678},  // R8
        {4'd9,  1'b1, 12'h038, 32'h8000_0101},  // R9
        {4'd9,  1'b0, 12'h038, 32'h8000_0101},  // R9
        {4'd9,  1'b1, 12'h03C, 32'h0000_0100},  // R9
        {4'd9,  1'b0, 12'h038, 32'h8000_0001},  // R9
        {4'd9,  1'b0, 12'h03C, 32'h0000_0000},  // R9
        {4'd11, 1'b1, 12'h000, 32'hFFFF_FFFF},  // R11
        {4'd11, 1'b0, 12'h000, 32'h01A2_0000},  // R11
        {4'd11, 1'b1, 12'h100, 32'hDEAD_BEEF},  // R11
        {4'd11, 1'b0, 12'h100, 32'h0000_0000},  // R11
        {4'd5,  1'b1, 12'h04C, 32'h0000_0001},  // R5
        {4'd5,  1'b0, 12'h04C, 32'h0000_0001}   // R5
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        // R1 reset state
        bus_read(1, 12'h030, 32'h0);
        bus_read(1, 12'h038, 32'h0);
        bus_read(1, 12'h008, 32'h0);
        check(1, 32'(led_out), 32'h0);
        check(1, 32'(flash_wp_n), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][44]) bus_write(VECS[i][43:32], VECS[i][31:0]);
            else             bus_read(int'(VECS[i][48:45]), VECS[i][43:32], VECS[i][31:0]);
        end

        // R4 / R5 pins follow their registers
        check(4, 32'(led_out), 32'h5A);
        check(5, 32'(flash_wp_n), 32'h1);

        // R5 / R6 status inputs change
        card_present = 1'b0; card_wprot = 1'b1; master_site2 = 1'b0;
        bus_read(5, 12'h048, 32'h2);
        bus_read(6, 12'h060, 32'h0);

        // R11 write to read-only switch register has no effect
        bus_write(12'h004, 32'h0);
        bus_read(11, 12'h004, 32'hA5A5_0F0F);

        // R10 warm reset keeps non-volatile flags
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        bus_read(10, 12'h030, 32'h0);
        bus_read(10, 12'h038, 32'h8000_0001);
        check(10, 32'(led_out), 32'h0);
        check(10, 32'(flash_wp_n), 32'h0);

        // R10 power-on reset clears non-volatile flags
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk); por_n = 1'b1;
        bus_read(10, 12'h038, 32'h0);

        // R12 hardware clear vs same-cycle set
        bus_write(12'h030, 32'h0000_000F);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h030; bus_wdata = 32'h5;
        flag_hw_clr = 32'hFF;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; flag_hw_clr = 32'h0;
        bus_read(12, 12'h030, 32'h0000_0005);
        @(negedge clk); flag_hw_clr = 32'h4;
        @(negedge clk); flag_hw_clr = 32'h0;
        bus_read(12, 12'h030, 32'h0000_0001);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule